// File: doc/BRIEF.md
# Two-Word Tickle Watchdog Timer

This block is a memory-mapped watchdog. Once armed it counts clock cycles toward a power-of-two limit chosen by a 5-bit delay field. If software does not service it in time, it raises a system reset request. Servicing takes two writes of fixed key words to two separate registers, in order. A wrong key, or the second key written with no correct first key before it, is treated as a runaway program and also raises a reset. Software can request a reset directly through a dedicated register.

Configuration writes land in a pending copy. The timer keeps running on the active copy until the next valid service moves the pending copy across. So neither enabling, disabling nor a new delay takes hold on the write alone. A 3-bit cause code records why the last reset was requested. It is readable at the first key register and is cleared only by the power-on reset input, so it is still there after the reset the watchdog itself requested.

Top module: `wdog_tickle_timer`

## Requirements
- R1: After the power-on reset (`hard_rst_n` low), `rst_req` is low, the cause code reads 0, the config register reads 0 and the watchdog is disabled, so no reset request is raised however long it waits.
- R2: The config register is at offset 0x4. Bit 31 is the enable and bits [4:0] are the delay. A read returns the last written (pending) value with all other bits 0. A read at offset 0x8 returns the cause code in bits [2:0], with the other bits 0.
- R3: A valid service is a write of 0xABCD1234 to offset 0x8 followed by a write of 0x4321DCBA to offset 0xC. The second write clears the timeout count and copies the pending config into the active config.
- R4: A config write has no effect on the running timer (enable, disable or delay) until the next valid service.
- R5: While active-enabled with delay d, a reset request rises 2^(d+1) cycles after the edge of the service's second write. The cause becomes 1 and the count restarts from zero.
- R6: Each reset request keeps `rst_req` high for exactly 4 cycles, starting on the cycle after the edge that caused it.
- R7: While active-enabled, each of the following requests a reset with cause 2: a value other than 0xABCD1234 written to offset 0x8; a value other than 0x4321DCBA written to offset 0xC; or 0x4321DCBA written to 0xC without a correct first key before it. While disabled these writes have no effect.
- R8: A write with bit 0 set to offset 0x0 requests a reset at once with cause 3, enabled or not. A write there with bit 0 clear does nothing.
- R9: A valid service whose second write falls on the very edge where the timeout would fire cancels that timeout: no reset is raised and the next timeout is a full period later.
- R10: A reset requested by the watchdog leaves the cause code and config unchanged after its pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| hard_rst_n | input | 1 | Active-low power-on reset; clears all state, including the cause |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 4 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| rst_req | output | 1 | System reset request pulse |

## Verification
Two functions can land on the same edge: the timeout firing and the completion of a valid service. The bench reaches this state by committing a delay of 2 (8-cycle period). It then times the first key so that the second key's write edge is exactly the edge on which the count reaches its limit. It judges the result by sampling `rst_req` just after that edge, where it must be low. It then samples again 8 cycles later, where a new pulse must appear, which shows that the count restarted from the service and not from the missed timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int DELAY_W = 5;
  localparam int EN_BIT  = 31;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFF_SOFT = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_KEY1 = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_KEY2 = 4'hC;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hABCD1234;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h4321DCBA;

  typedef enum logic [2:0] {
    CAUSE_HARD    = 3'd0,
    CAUSE_TIMEOUT = 3'd1,
    CAUSE_BADKEY  = 3'd2,
    CAUSE_SOFT    = 3'd3,
    CAUSE_USER    = 3'd4
  } cause_e;

  typedef struct packed {
    logic               en;
    logic [DELAY_W-1:0] delay;
  } wcfg_t;

  function automatic wcfg_t cfg_from_word(logic [DATA_W-1:0] w);
    wcfg_t c;
    c.en    = w[EN_BIT];
    c.delay = w[DELAY_W-1:0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(wcfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[DELAY_W-1:0] = c.delay;
    return w;
  endfunction

endpackage

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [DELAY_W-1:0] delay,
  input  logic               clear,
  output logic               timeout_evt
);

  localparam int CNT_W = (1 << DELAY_W) + 1;

  // Last count value of a 2^(d+1)-cycle period
  function automatic logic [CNT_W-1:0] last_tick(logic [DELAY_W-1:0] d);
    logic [CNT_W-1:0] one;
    one = 1;
    return (one << ({1'b0, d} + 1'b1)) - one;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             at_limit;

  assign at_limit    = en && (cnt == last_tick(delay));
  assign timeout_evt = at_limit && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clear || !en || at_limit) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (cnt == '0));

  assert_clear_on_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/wdt_tickle_chk.sv
module wdt_tickle_chk
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key1_wr,
  input  logic              key2_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              guard_en,
  output logic              tickle_ok,
  output logic              tickle_bad
);

  logic armed;

  always_comb begin
    tickle_ok  = key2_wr && armed && (wdata == KEY_SECOND);
    tickle_bad = guard_en &&
                 ((key1_wr && (wdata != KEY_FIRST)) || (key2_wr && !tickle_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (key1_wr) armed <= (wdata == KEY_FIRST);
    else if (key2_wr) armed <= 1'b0;
  end

  // R3: a completed service consumes the first key
  assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tickle_ok |=> !armed);

  // R7: second key with nothing armed never counts as a service
  assert_needs_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key2_wr && $past(!key1_wr) && !armed) |-> !tickle_ok);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (fire)          left <= CW'(LEN);
    else if (left != '0)    left <= left - 1'b1;
  end

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);

  assert_pulse_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !fire) |=> (left == $past(left) - 1'b1));

  always_comb begin
    assert_pulse_bound_R6: assert (left <= CW'(LEN));
  end

endmodule

// File: rtl/wdog_tickle_timer.sv
module wdog_tickle_timer
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);

  wcfg_t  pend_q, act_q;
  cause_e cause_q;

  // Named internal events
  logic cfg_wr, key1_wr, key2_wr, soft_evt;
  logic tickle_ok, tickle_bad, timeout_evt, fire;

  assign cfg_wr   = wr_en && (addr == OFF_CFG);
  assign key1_wr  = wr_en && (addr == OFF_KEY1);
  assign key2_wr  = wr_en && (addr == OFF_KEY2);
  assign soft_evt = wr_en && (addr == OFF_SOFT) && wdata[0];
  assign fire     = soft_evt || tickle_bad || timeout_evt;

  wdt_tickle_chk u_chk (
    .clk        (clk),
    .rst_n      (hard_rst_n),
    .key1_wr    (key1_wr),
    .key2_wr    (key2_wr),
    .wdata      (wdata),
    .guard_en   (act_q.en),
    .tickle_ok  (tickle_ok),
    .tickle_bad (tickle_bad)
  );

  wdt_timer #(.DELAY_W(DELAY_W)) u_timer (
    .clk         (clk),
    .rst_n       (hard_rst_n),
    .en          (act_q.en),
    .delay       (act_q.delay),
    .clear       (tickle_ok),
    .timeout_evt (timeout_evt)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (hard_rst_n),
    .fire  (fire),
    .pulse (rst_req)
  );

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (cfg_wr)    pend_q <= cfg_from_word(wdata);
      if (tickle_ok) act_q  <= pend_q;
    end
  end

  // Priority: software request, then bad key, then timeout
  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)      cause_q <= CAUSE_HARD;
    else if (soft_evt)    cause_q <= CAUSE_SOFT;
    else if (tickle_bad)  cause_q <= CAUSE_BADKEY;
    else if (timeout_evt) cause_q <= CAUSE_TIMEOUT;
  end

  always_comb begin
    unique case (addr)
      OFF_CFG:  rdata = cfg_to_word(pend_q);
      OFF_KEY1: rdata = {{(DATA_W-3){1'b0}}, cause_q};
      default:  rdata = '0;
    endcase
  end

  assert_commit_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    tickle_ok |=> (act_q == $past(pend_q)));

  assert_hold_active_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !tickle_ok |=> (act_q == $past(act_q)));

  assert_soft_cause_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_evt |=> (cause_q == CAUSE_SOFT));

  assert_badkey_cause_R7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (tickle_bad && !soft_evt) |=> (cause_q == CAUSE_BADKEY));

  assert_timeout_cause_R5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (timeout_evt && !soft_evt && !tickle_bad) |=> (cause_q == CAUSE_TIMEOUT));

  assert_service_wins_R9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    tickle_ok |-> !timeout_evt);

  assert_cause_kept_R10: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !fire |=> $stable(cause_q));

endmodule

// File: tb/wdog_tickle_timer_test.sv
`timescale 1ns/1ps
module wdog_tickle_timer_test;

  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_tickle_timer uut (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rst_req    (rst_req)
  );

  localparam logic [3:0]  A_SOFT = 4'h0, A_CFG = 4'h4, A_K1 = 4'h8, A_K2 = 4'hC;
  localparam logic [31:0] K1 = 32'hABCD1234, K2 = 32'h4321DCBA;

  // {addr, data, expected rst_req after write, expected cause, requirement}
  localparam int NV = 17;
  localparam logic [43:0] VECS [NV] = '{
    {A_CFG,  32'h80000014, 1'b0, 3'd0, 4'd2},  // R2 pending only
    {A_K2,   K2,           1'b0, 3'd0, 4'd7},  // R7 disabled: ignored
    {A_K1,   K1,           1'b0, 3'd0, 4'd3},  // R3
    {A_K2,   K2,           1'b0, 3'd0, 4'd3},  // R3 commit enable
    {A_K1,   32'h00000001, 1'b1, 3'd2, 4'd7},  // R7 wrong first key
    {A_K1,   K1,           1'b0, 3'd2, 4'd3},  // R3
    {A_K2,   32'h00000000, 1'b1, 3'd2, 4'd7},  // R7 wrong second key
    {A_K1,   K1,           1'b0, 3'd2, 4'd3},  // R3
    {A_K2,   K2,           1'b0, 3'd2, 4'd3},  // R3
    {A_K2,   K2,           1'b1, 3'd2, 4'd7},  // R7 second key without first
    {A_SOFT, 32'h00000000, 1'b0, 3'd2, 4'd8},  // R8 bit0 clear: nothing
    {A_SOFT, 32'h00000001, 1'b1, 3'd3, 4'd8},  // R8 soft request
    {A_CFG,  32'h00000014, 1'b0, 3'd3, 4'd4},  // R4 disable pending
    {A_K1,   32'h00000001, 1'b1, 3'd2, 4'd4},  // R4 still enabled
    {A_K1,   K1,           1'b0, 3'd2, 4'd3},  // R3
    {A_K2,   K2,           1'b0, 3'd2, 4'd3},  // R3 commit disable
    {A_K1,   32'h00000001, 1'b0, 3'd2, 4'd7}   // R7 disabled: ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; the write takes the next posedge; returns at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic service();
    wr(A_K1, K1);
    wr(A_K2, K2);
  endtask

  function automatic int period_of(input int d);
    return 1 << (d + 1);
  endfunction

  logic [31:0] v;
  int L;

  initial begin
    wait_cyc(3);
    // Reset state
    chk("R1 rst_req in reset", {31'b0, rst_req}, 32'd0);
    hard_rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 rst_req after reset", {31'b0, rst_req}, 32'd0);
    rd(A_CFG, v);  chk("R1 config after reset", v, 32'h0);
    rd(A_K1, v);   chk("R1 cause after reset", v, 32'h0);
    wait_cyc(40);
    chk("R1 disabled: no request", {31'b0, rst_req}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  va;
      logic [31:0] vd;
      logic        vr;
      logic [2:0]  vc;
      logic [3:0]  vq;
      {va, vd, vr, vc, vq} = VECS[i];
      wr(va, vd);
      chk($sformatf("R%0d row %0d rst_req", vq, i), {31'b0, rst_req}, {31'b0, vr});
      rd(A_K1, v);
      chk($sformatf("R%0d row %0d cause", vq, i), v, {29'b0, vc});
      if (i == 0) begin
        rd(A_CFG, v);
        chk("R2 config readback", v, 32'h80000014);
      end
      wait_cyc(6);
    end

    // Timeout, pending delay, pulse width, cause kept
    L = period_of(2);
    wr(A_CFG, 32'h80000002);
    service();                       // elapsed 0
    wr(A_CFG, 32'h80000001);         // elapsed 1, pending only
    wait_cyc(period_of(1) - 1);      // elapsed 4
    chk("R4 new delay not yet active", {31'b0, rst_req}, 32'd0);
    wait_cyc(L - 1 - period_of(1));  // elapsed 7
    chk("R5 no request before period", {31'b0, rst_req}, 32'd0);
    wait_cyc(1);                     // elapsed 8
    chk("R5 request at period", {31'b0, rst_req}, 32'd1);
    rd(A_K1, v); chk("R5 timeout cause", v, 32'd1);
    wait_cyc(3);                     // elapsed 11
    chk("R6 pulse 4th cycle", {31'b0, rst_req}, 32'd1);
    wait_cyc(1);                     // elapsed 12
    chk("R6 pulse ended", {31'b0, rst_req}, 32'd0);
    rd(A_K1, v); chk("R10 cause kept", v, 32'd1);
    rd(A_CFG, v); chk("R10 config kept", v, 32'h80000001);
    wait_cyc(L / 2);                 // elapsed 16
    chk("R5 count restarted", {31'b0, rst_req}, 32'd1);

    // Service on the timeout edge
    wr(A_CFG, 32'h80000002);
    service();                       // elapsed 0
    wait_cyc(L - 3);                 // elapsed 5
    wr(A_K1, K1);                    // elapsed 6
    wait_cyc(1);                     // elapsed 7
    wr(A_K2, K2);                    // write edge = timeout edge, elapsed 8
    chk("R9 service cancels timeout", {31'b0, rst_req}, 32'd0);
    rd(A_K1, v); chk("R9 cause unchanged", v, 32'd1);
    wait_cyc(L - 1);
    chk("R9 no early request", {31'b0, rst_req}, 32'd0);
    wait_cyc(1);
    chk("R9 full period after service", {31'b0, rst_req}, 32'd1);

    // Disable through service
    wr(A_CFG, 32'h00000002);
    service();
    wait_cyc(3 * L);
    chk("R4 disable committed", {31'b0, rst_req}, 32'd0);
    rd(A_CFG, v); chk("R2 config readback disabled", v, 32'h00000002);

    // Power-on reset during a pulse
    wr(A_CFG, 32'h80000014);
    service();
    wr(A_K1, 32'h12345678);
    chk("R7 bad key enabled", {31'b0, rst_req}, 32'd1);
    hard_rst_n = 1'b0;
    wait_cyc(1);
    chk("R1 reset drops request", {31'b0, rst_req}, 32'd0);
    rd(A_K1, v);  chk("R1 reset clears cause", v, 32'd0);
    rd(A_CFG, v); chk("R1 reset clears config", v, 32'd0);
    hard_rst_n = 1'b1;
    wait_cyc(50);
    chk("R1 disabled after reset", {31'b0, rst_req}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule